// File: doc/BRIEF.md
# Ethernet MAC Host Register Block

This block is the byte-wide configuration register file that sits between a host bus and the rest of an Ethernet media access controller. The host presents a 5-bit register offset together with a read or write strobe. The block keeps the receive frame control, MAC configuration and bus-interface configuration bytes. It also keeps an interrupt mask, an interrupt status register with clear-on-read behaviour, and a fixed 16-bit device identifier. All of these values are exported to the surrounding datapath. The datapath itself (FIFOs, frame engines, DMA, transceiver) lives outside this block.

The 48-bit station address and the 64-bit multicast hash filter are not mapped one register per byte. The host first writes an address-mode register to select which table to load. It then writes consecutive bytes to a single load port, and a hidden byte pointer steps through the lanes. When the last lane of the table is written, the mode bit drops by itself and the pointer returns to zero.

Interrupt sources arrive as a vector of event pulses. They are ORed into the status register, and the status register is cleared when the host reads it. A single interrupt line reports any status bit that is not masked.

Top module: `enet_mac_regs`

## Requirements
- R1: After reset, offset 5 (receive frame control) reads 0x01. Offsets 8, 9, 11, 13 and 18 read 0x00. The address tables, soft_rst_o and irq_o are all 0.
- R2: Writes to offset 5 (receive control), offset 9 (interrupt mask), offset 11 (bus config) and offset 13 (MAC config) store the byte. The byte reads back at the same offset and appears on the matching output after the write edge.
- R3: Writing offset 11 with bit 0 set raises soft_rst_o for exactly the one cycle after the write edge. Bit 0 is stored as 0, so it always reads back as 0.
- R4: Each cycle, event_i is ORed into the interrupt status register. A read of offset 8 returns the flags accumulated so far and clears them.
- R5: If event_i is nonzero in the same cycle as a status read, those event bits are not included in that read's data. They remain pending for the next read.
- R6: irq_o is high exactly when some status bit is 1 and the same bit of the mask is 0.
- R7: The device identifier is 0x0941. Offset 16 reads 0x41 and offset 17 reads 0x09. Writes to these offsets do not change them.
- R8: Offset 18 is the address-mode register, and it reads back the stored value. Bit 1 selects hash filter loading, bit 2 selects station address loading, and bit 7 is a stored change flag. If a write sets both bit 1 and bit 2, bit 2 is stored as 0. Any write that leaves bit 1 or bit 2 set resets the byte pointer to 0.
- R9: While bit 1 of offset 18 is set, the n-th write to offset 20 places its byte in bits [8n+7:8n] of hash_filt_o, counting n from 0. After the 8th byte, bit 1 clears.
- R10: While bit 2 of offset 18 is set, the n-th write to offset 21 places its byte in bits [8n+7:8n] of station_addr_o, counting n from 0. After the 6th byte, bit 2 clears.
- R11: A write to offset 20 or 21 while the matching mode bit is clear leaves both address tables unchanged.
- R12: Offsets other than 5, 8, 9, 11, 13, 16, 17 and 18 read 0x00, and writing them changes no output. The load ports at offsets 20 and 21 also read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ofs_i | input | 5 | Register offset |
| wr_i | input | 1 | Write strobe, one cycle per byte |
| rd_i | input | 1 | Read strobe; triggers the status clear-on-read side effect |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for ofs_i (combinational) |
| event_i | input | 8 | Interrupt event pulses, one bit per source |
| irq_o | output | 1 | Combined unmasked interrupt |
| soft_rst_o | output | 1 | One-cycle software reset pulse |
| rx_ctl_o | output | 8 | Receive frame control |
| bus_cfg_o | output | 8 | Bus-interface configuration (bit 0 always 0) |
| mac_cfg_o | output | 8 | MAC configuration |
| irq_mask_o | output | 8 | Interrupt mask |
| station_addr_o | output | 48 | Station (physical) address, byte n at bits [8n+7:8n] |
| hash_filt_o | output | 64 | Logical address hash filter, byte n at bits [8n+7:8n] |

## Verification
The collision that matters is an event pulse landing in the same cycle as the host's clear-on-read of the status register. A naive clear would drop that event. The bench holds one pattern in status, then issues the status read while driving a different pattern on event_i. It expects the read to return only the old pattern, the next read to return only the new one, and a third read to return zero. A similar overlap exists in the address loader, where a rewrite of the mode register during a partial load must restart the pointer. The bench judges that case by the lane in which the next byte lands.

// File: rtl/enet_regs_pkg.sv
package enet_regs_pkg;
  localparam int unsigned OFS_W = 5;
  localparam int unsigned BYTE_W = 8;
  typedef logic [OFS_W-1:0] ofs_t;
  typedef logic [BYTE_W-1:0] byte_t;

  localparam ofs_t OFS_RXCTL  = 5'd5;
  localparam ofs_t OFS_ISTAT  = 5'd8;
  localparam ofs_t OFS_IMASK  = 5'd9;
  localparam ofs_t OFS_BUSCFG = 5'd11;
  localparam ofs_t OFS_MACCFG = 5'd13;
  localparam ofs_t OFS_ID_LO  = 5'd16;
  localparam ofs_t OFS_ID_HI  = 5'd17;
  localparam ofs_t OFS_ADRCFG = 5'd18;
  localparam ofs_t OFS_HASHLD = 5'd20;
  localparam ofs_t OFS_STALD  = 5'd21;

  localparam int unsigned BIT_SWRST  = 0;
  localparam int unsigned BIT_HASHLD = 1;
  localparam int unsigned BIT_STALD  = 2;
  localparam int unsigned BIT_ADRCHG = 7;
endpackage

// File: rtl/enet_irq_ctrl.sv
module enet_irq_ctrl #(
  parameter int unsigned N_SRC = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] event_i,
  input  logic             clr_i,
  input  logic             mask_we_i,
  input  logic [N_SRC-1:0] mask_d_i,
  output logic [N_SRC-1:0] stat_o,
  output logic [N_SRC-1:0] mask_o,
  output logic             irq_o
);
  logic [N_SRC-1:0] stat_q, mask_q;

  // events in the clearing cycle survive the clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else if (clr_i) stat_q <= event_i;
    else stat_q <= stat_q | event_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else if (mask_we_i) mask_q <= mask_d_i;
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign irq_o  = |(stat_q & ~mask_q);
endmodule

// File: rtl/enet_addr_loader.sv
module enet_addr_loader
  import enet_regs_pkg::*;
#(
  parameter int unsigned HASH_BYTES = 8,
  parameter int unsigned STA_BYTES  = 6
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         cfg_we_i,
  input  logic                         hash_we_i,
  input  logic                         sta_we_i,
  input  byte_t                        wdata_i,
  output byte_t                        cfg_o,
  output logic [HASH_BYTES*BYTE_W-1:0] hash_o,
  output logic [STA_BYTES*BYTE_W-1:0]  sta_o
);
  localparam int unsigned MAX_BYTES = (HASH_BYTES > STA_BYTES) ? HASH_BYTES : STA_BYTES;
  localparam int unsigned PTR_W     = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;
  localparam logic [PTR_W-1:0] HASH_LAST = PTR_W'(HASH_BYTES - 1);
  localparam logic [PTR_W-1:0] STA_LAST  = PTR_W'(STA_BYTES - 1);

  byte_t cfg_q, cfg_in;
  logic [PTR_W-1:0] ptr_q;
  byte_t hash_q [HASH_BYTES];
  byte_t sta_q  [STA_BYTES];
  logic hash_en, sta_en;

  assign hash_en = hash_we_i && cfg_q[BIT_HASHLD];
  assign sta_en  = sta_we_i  && cfg_q[BIT_STALD];

  // hash filter loading wins over station address loading
  always_comb begin
    cfg_in = wdata_i;
    if (wdata_i[BIT_HASHLD]) cfg_in[BIT_STALD] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      ptr_q <= '0;
    end else if (cfg_we_i) begin
      cfg_q <= cfg_in;
      if (cfg_in[BIT_HASHLD] || cfg_in[BIT_STALD]) ptr_q <= '0;
    end else if (hash_en) begin
      if (ptr_q == HASH_LAST) begin
        cfg_q[BIT_HASHLD] <= 1'b0;
        ptr_q <= '0;
      end else begin
        ptr_q <= ptr_q + 1'b1;
      end
    end else if (sta_en) begin
      if (ptr_q == STA_LAST) begin
        cfg_q[BIT_STALD] <= 1'b0;
        ptr_q <= '0;
      end else begin
        ptr_q <= ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < HASH_BYTES; i++) hash_q[i] <= '0;
    end else if (hash_en && !cfg_we_i) begin
      for (int i = 0; i < HASH_BYTES; i++)
        if (ptr_q == PTR_W'(i)) hash_q[i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STA_BYTES; i++) sta_q[i] <= '0;
    end else if (sta_en && !cfg_we_i && !hash_en) begin
      for (int i = 0; i < STA_BYTES; i++)
        if (ptr_q == PTR_W'(i)) sta_q[i] <= wdata_i;
    end
  end

  for (genvar g = 0; g < HASH_BYTES; g++) begin : g_hash_lane
    assign hash_o[g*BYTE_W +: BYTE_W] = hash_q[g];
  end
  for (genvar g = 0; g < STA_BYTES; g++) begin : g_sta_lane
    assign sta_o[g*BYTE_W +: BYTE_W] = sta_q[g];
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/enet_mac_regs.sv
module enet_mac_regs
  import enet_regs_pkg::*;
#(
  parameter logic [15:0] DEV_ID     = 16'h0941,
  parameter int unsigned HASH_BYTES = 8,
  parameter int unsigned STA_BYTES  = 6
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [4:0]                   ofs_i,
  input  logic                         wr_i,
  input  logic                         rd_i,
  input  logic [7:0]                   wdata_i,
  output logic [7:0]                   rdata_o,
  input  logic [7:0]                   event_i,
  output logic                         irq_o,
  output logic                         soft_rst_o,
  output logic [7:0]                   rx_ctl_o,
  output logic [7:0]                   bus_cfg_o,
  output logic [7:0]                   mac_cfg_o,
  output logic [7:0]                   irq_mask_o,
  output logic [STA_BYTES*8-1:0]       station_addr_o,
  output logic [HASH_BYTES*8-1:0]      hash_filt_o
);
  byte_t rx_ctl_q, bus_cfg_q, mac_cfg_q, int_stat, addr_cfg;
  logic  soft_rst_q;

  logic wr_rx, wr_bus, wr_mac, wr_mask, wr_acfg, wr_hash, wr_sta, rd_stat;
  assign wr_rx   = wr_i && (ofs_i == OFS_RXCTL);
  assign wr_bus  = wr_i && (ofs_i == OFS_BUSCFG);
  assign wr_mac  = wr_i && (ofs_i == OFS_MACCFG);
  assign wr_mask = wr_i && (ofs_i == OFS_IMASK);
  assign wr_acfg = wr_i && (ofs_i == OFS_ADRCFG);
  assign wr_hash = wr_i && (ofs_i == OFS_HASHLD);
  assign wr_sta  = wr_i && (ofs_i == OFS_STALD);
  assign rd_stat = rd_i && (ofs_i == OFS_ISTAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_ctl_q   <= 8'h01;
      bus_cfg_q  <= '0;
      mac_cfg_q  <= '0;
      soft_rst_q <= 1'b0;
    end else begin
      soft_rst_q <= wr_bus && wdata_i[BIT_SWRST];
      if (wr_rx)  rx_ctl_q  <= wdata_i;
      if (wr_mac) mac_cfg_q <= wdata_i;
      // reset request is acknowledged immediately, never stored
      if (wr_bus) bus_cfg_q <= wdata_i & ~(byte_t'(1) << BIT_SWRST);
    end
  end

  enet_irq_ctrl #(.N_SRC(BYTE_W)) i_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .event_i   (event_i),
    .clr_i     (rd_stat),
    .mask_we_i (wr_mask),
    .mask_d_i  (wdata_i),
    .stat_o    (int_stat),
    .mask_o    (irq_mask_o),
    .irq_o     (irq_o)
  );

  enet_addr_loader #(.HASH_BYTES(HASH_BYTES), .STA_BYTES(STA_BYTES)) i_addr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_we_i  (wr_acfg),
    .hash_we_i (wr_hash),
    .sta_we_i  (wr_sta),
    .wdata_i   (wdata_i),
    .cfg_o     (addr_cfg),
    .hash_o    (hash_filt_o),
    .sta_o     (station_addr_o)
  );

  always_comb begin
    unique case (ofs_i)
      OFS_RXCTL:  rdata_o = rx_ctl_q;
      OFS_ISTAT:  rdata_o = int_stat;
      OFS_IMASK:  rdata_o = irq_mask_o;
      OFS_BUSCFG: rdata_o = bus_cfg_q;
      OFS_MACCFG: rdata_o = mac_cfg_q;
      OFS_ID_LO:  rdata_o = DEV_ID[7:0];
      OFS_ID_HI:  rdata_o = DEV_ID[15:8];
      OFS_ADRCFG: rdata_o = addr_cfg;
      default:    rdata_o = '0;
    endcase
  end

  assign soft_rst_o = soft_rst_q;
  assign rx_ctl_o   = rx_ctl_q;
  assign bus_cfg_o  = bus_cfg_q;
  assign mac_cfg_o  = mac_cfg_q;
endmodule

// File: rtl/enet_mac_regs_chk.sv
module enet_mac_regs_chk #(
  parameter logic [15:0] DEV_ID = 16'h0941,
  parameter int unsigned STA_W  = 48,
  parameter int unsigned HASH_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [4:0]        ofs_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [7:0]        wdata_i,
  input logic [7:0]        rdata_o,
  input logic [7:0]        event_i,
  input logic              irq_o,
  input logic              soft_rst_o,
  input logic [7:0]        bus_cfg_o,
  input logic [7:0]        irq_mask_o,
  input logic [STA_W-1:0]  station_addr_o,
  input logic [HASH_W-1:0] hash_filt_o,
  input logic [7:0]        stat_i,
  input logic [7:0]        cfg_i
);
  AST_STAT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && ofs_i == 5'd8) |=> (stat_i == $past(event_i))); // R5
  AST_STAT_ACCUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && ofs_i == 5'd8) |=> (stat_i == ($past(stat_i) | $past(event_i)))); // R4
  AST_SWRST_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && ofs_i == 5'd11 && wdata_i[0]) |=> (soft_rst_o && !bus_cfg_o[0])); // R3
  AST_SWRST_ONESHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> !soft_rst_o || $past(wr_i && ofs_i == 5'd11 && wdata_i[0])); // R3
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_mask_o == 8'hFF) |-> !irq_o); // R6
  AST_ID_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ofs_i == 5'd16) |-> (rdata_o == DEV_ID[7:0])); // R7
  AST_MODE_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && ofs_i == 5'd18 && wdata_i[1] && wdata_i[2]) |=> (cfg_i[1] && !cfg_i[2])); // R8
  AST_MODE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfg_i[1] && cfg_i[2])); // R8
  AST_STA_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && ofs_i == 5'd21 && !cfg_i[2]) |=> $stable(station_addr_o)); // R11
  AST_HASH_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && ofs_i == 5'd20 && !cfg_i[1]) |=> $stable(hash_filt_o)); // R11
endmodule

bind enet_mac_regs enet_mac_regs_chk #(
  .DEV_ID(DEV_ID), .STA_W(STA_BYTES*8), .HASH_W(HASH_BYTES*8)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ofs_i(ofs_i), .wr_i(wr_i), .rd_i(rd_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .event_i(event_i), .irq_o(irq_o),
  .soft_rst_o(soft_rst_o), .bus_cfg_o(bus_cfg_o), .irq_mask_o(irq_mask_o),
  .station_addr_o(station_addr_o), .hash_filt_o(hash_filt_o),
  .stat_i(int_stat), .cfg_i(addr_cfg)
);

// File: tb/test_enet_mac_regs.sv
module test_enet_mac_regs;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] ofs = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0, rdata, evt = '0;
  logic irq, soft_rst;
  logic [7:0] rx_ctl, bus_cfg, mac_cfg, irq_mask;
  logic [47:0] sta;
  logic [63:0] hash;

  int n_cmp = 0, n_bad = 0;

  enet_mac_regs i_enet_mac_regs (
    .clk_i(clk), .rst_ni(rst_n), .ofs_i(ofs), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .event_i(evt), .irq_o(irq),
    .soft_rst_o(soft_rst), .rx_ctl_o(rx_ctl), .bus_cfg_o(bus_cfg),
    .mac_cfg_o(mac_cfg), .irq_mask_o(irq_mask), .station_addr_o(sta),
    .hash_filt_o(hash)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); ofs = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); ofs = a; rd = 1'b1; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic pulse_evt(input logic [7:0] e);
    @(negedge clk); evt = e;
    @(negedge clk); evt = '0;
  endtask

  function automatic bit is_impl(input int o);
    return o == 5 || o == 8 || o == 9 || o == 11 || o == 13 || o == 16 || o == 17 || o == 18;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [47:0] exp_sta;
    logic [63:0] exp_hash;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    rd_reg(5'd5, d);  check("R1 rxctl", d, 8'h01);
    rd_reg(5'd8, d);  check("R1 istat", d, 8'h00);
    rd_reg(5'd9, d);  check("R1 imask", d, 8'h00);
    rd_reg(5'd11, d); check("R1 buscfg", d, 8'h00);
    rd_reg(5'd13, d); check("R1 maccfg", d, 8'h00);
    rd_reg(5'd18, d); check("R1 adrcfg", d, 8'h00);
    check("R1 tables", {sta, hash}, '0);
    check("R1 pins", {irq, soft_rst}, 2'b00);

    // R2 plain registers
    wr_reg(5'd5, 8'h3C);  rd_reg(5'd5, d);  check("R2 rxctl rd", d, 8'h3C); check("R2 rxctl out", rx_ctl, 8'h3C);
    wr_reg(5'd13, 8'h5A); rd_reg(5'd13, d); check("R2 mac rd", d, 8'h5A);   check("R2 mac out", mac_cfg, 8'h5A);
    wr_reg(5'd9, 8'hC3);  rd_reg(5'd9, d);  check("R2 mask rd", d, 8'hC3);  check("R2 mask out", irq_mask, 8'hC3);
    wr_reg(5'd11, 8'h72); rd_reg(5'd11, d); check("R2 bus rd", d, 8'h72);   check("R2 no swrst", soft_rst, 1'b0);

    // R3 software reset bit
    wr_reg(5'd11, 8'hA5);
    check("R3 pulse", soft_rst, 1'b1);
    check("R3 stored", bus_cfg, 8'hA4);
    @(negedge clk);
    check("R3 one cycle", soft_rst, 1'b0);
    rd_reg(5'd11, d); check("R3 readback", d, 8'hA4);

    // R4 R6 sweep of event and mask patterns
    for (int e = 0; e < 256; e++) begin
      logic [7:0] f, m, acc;
      f = 8'((e * 7 + 3) & 255);
      m = 8'(e) ^ 8'h3C;
      acc = 8'(e) | f;
      pulse_evt(8'(e));
      pulse_evt(f);
      wr_reg(5'd9, m);
      check("R6 irq", irq, |(acc & ~m));
      rd_reg(5'd8, d);
      check("R4 accumulate", d, acc);
      check("R4 cleared irq", irq, 1'b0);
    end
    wr_reg(5'd9, 8'h00);
    rd_reg(5'd8, d); check("R4 empty after read", d, 8'h00);

    // R5 event concurrent with status read
    pulse_evt(8'h03);
    @(negedge clk); ofs = 5'd8; rd = 1'b1; evt = 8'h5A; #1 d = rdata;
    @(negedge clk); rd = 1'b0; evt = '0;
    check("R5 old flags", d, 8'h03);
    check("R5 irq pending", irq, 1'b1);
    rd_reg(5'd8, d); check("R5 kept event", d, 8'h5A);
    rd_reg(5'd8, d); check("R5 then empty", d, 8'h00);

    // R7 identifier
    wr_reg(5'd16, 8'hFF); wr_reg(5'd17, 8'hFF);
    rd_reg(5'd16, d); check("R7 id low", d, 8'h41);
    rd_reg(5'd17, d); check("R7 id high", d, 8'h09);

    // R8 mode priority and stored flag
    wr_reg(5'd18, 8'h06); rd_reg(5'd18, d); check("R8 prio", d, 8'h02);
    wr_reg(5'd18, 8'h80); rd_reg(5'd18, d); check("R8 flag", d, 8'h80);

    // R9 hash filter load
    exp_hash = '0;
    wr_reg(5'd18, 8'h02);
    for (int i = 0; i < 8; i++) begin
      logic [7:0] b;
      b = 8'(i * 17 + 3);
      exp_hash[i*8 +: 8] = b;
      wr_reg(5'd20, b);
      rd_reg(5'd18, d);
      check("R9 mode bit", d[1], (i < 7) ? 1'b1 : 1'b0);
    end
    check("R9 hash", hash, exp_hash);
    check("R9 sta untouched", sta, 48'h0);

    // R10 station address load, with pointer restart (R8)
    exp_sta = '0;
    wr_reg(5'd18, 8'h04);
    wr_reg(5'd21, 8'hEE); wr_reg(5'd21, 8'hDD); wr_reg(5'd21, 8'hCC);
    wr_reg(5'd18, 8'h04);
    for (int i = 0; i < 6; i++) begin
      logic [7:0] b;
      b = 8'(8'hA0 + i * 5);
      exp_sta[i*8 +: 8] = b;
      wr_reg(5'd21, b);
      rd_reg(5'd18, d);
      check("R10 mode bit", d[2], (i < 5) ? 1'b1 : 1'b0);
    end
    check("R8 R10 station", sta, exp_sta);

    // R11 loads with mode clear
    wr_reg(5'd21, 8'h11); wr_reg(5'd20, 8'h22);
    check("R11 station kept", sta, exp_sta);
    check("R11 hash kept", hash, exp_hash);

    // R12 unimplemented offsets
    for (int o = 0; o < 32; o++) begin
      if (!is_impl(o)) begin
        rd_reg(5'(o), d);
        check("R12 read zero", d, 8'h00);
      end
    end
    for (int o = 0; o < 32; o++)
      if (!is_impl(o)) wr_reg(5'(o), 8'hFF);
    check("R12 regs kept", {rx_ctl, bus_cfg, mac_cfg, irq_mask}, {8'h3C, 8'hA4, 8'h5A, 8'h00});
    check("R12 tables kept", {sta, hash}, {exp_sta, exp_hash});
    rd_reg(5'd18, d); check("R12 adrcfg kept", d, 8'h00);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule